// File: doc/BRIEF.md
# Bit-Serial Save-Memory Device Emulator

This block plays the device end of a save-memory cartridge that hangs off a game-controller port. The host owns two lines: a bit clock and a data line that doubles as the pad strobe. The block answers on two return lines, a data bit and an identification bit. It also raises a lockout flag that tells the surrounding port logic to stop passing the ordinary controller through. Storage is a bit-addressable array held inside the block, and every transfer is a run of single bits.

A transaction starts when the host clocks a sync byte into the block's hunting window. The block then gives two identification bits and takes a 31-bit command header. That header names the direction, a start position in 128-byte steps, a byte count and an extra count of single bits. The block then streams that many bits out of memory or into it. A write ends with two status bits. Every command ends with three trailer bits from the host. Illegal activity on the data line throws the block back to idle. A host that stops early leaves the block waiting, with the lockout still raised, until enough further clocks have arrived.

Top module: `save_mem_emu`

## Requirements
- R1: While idle, each host clock rising edge shifts `host_data` into an 8-bit window, with earlier bits moving toward the MSB. `pad_lock` rises only on the rising edge that makes the window equal 0xA8 (bits sent 1,0,1,0,1,0,0,0). Bit patterns that never form 0xA8 leave it low.
- R2: After sync, the first bit the host reads shows `ret_id`=1 and `ret_data`=0, and the second shows `ret_id`=0 and `ret_data`=1. Each bit is read before its host clock rising edge.
- R3: The header is 31 bits sampled on host clock rising edges, in this order: a direction bit (1 read, 0 write), a 10-bit address LSB first, a 3-bit bit count LSB first, then a 17-bit byte length LSB first.
- R4: A command moves exactly length*8 + bitcount bits. A header with length 0 and bitcount 1 is a one-bit read. A zero-size read goes straight to the trailer, and a zero-size write goes straight to the status bits.
- R5: Bit k of a transfer uses memory bit address*1024 + k, taken modulo the array size. Within a byte the LSB comes first, and the walk does not stop at 128-byte or 512-byte boundaries.
- R6: A write touches only the bits it transfers, so a partial-byte write keeps the other bits of that byte. Locations that have never been written read as 1.
- R7: After the last write bit, the next two host reads return `ret_data` 1 and then 0.
- R8: After each command the block consumes three trailer clocks. It then drops `pad_lock` and hunts for sync again from an empty window.
- R9: If `host_data` changes while the host clock is high and the block is busy, it returns to idle, clearing `pad_lock`, `ret_data` and `ret_id`.
- R10: If `host_data` changes twice between two host clock rising edges while the block is busy, it returns to idle.
- R11: When the host stops mid-transfer, `pad_lock` stays high. Later clocks, including a sync byte, are taken as further transfer bits, and the stream continues where it stopped. Only after the remaining count and the trailer have been clocked through does the block go idle.
- R12: Return lines change only after a host clock falling edge or on an abort. `ret_id` is never high while idle, and `ret_data` is 0 while idle and after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both host lines are sampled on it |
| rst_n | input | 1 | Active-low synchronous reset |
| host_clk | input | 1 | Host bit clock |
| host_data | input | 1 | Host data / pad strobe line |
| ret_data | output | 1 | Returned data bit |
| ret_id | output | 1 | Returned identification bit |
| pad_lock | output | 1 | High while a transaction holds the port; blocks controller passthrough |

## Verification
The assertions assume that both host lines are synchronous to `clk`. They also assume the data line never changes in the same sample as a host clock edge, so that every change counts as either a high-phase or a low-phase change. The bench drives both lines only on falling system clock edges, holds each host clock phase for three system cycles, and changes data once per bit while the clock is low. The only exceptions are the two deliberate abort sequences, and those too keep data changes away from clock edges.

// File: rtl/save_mem_emu.sv
module save_mem_emu #(
  parameter int          MEM_AW    = 12,
  parameter int          ADDR_W    = 10,
  parameter int          BC_W      = 3,
  parameter int          LEN_W     = 17,
  parameter int          STEP_SH   = 10,
  parameter logic [7:0]  SYNC_BYTE = 8'hA8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_clk,
  input  logic host_data,
  output logic ret_data,
  output logic ret_id,
  output logic pad_lock
);
  localparam int HDR_W    = 1 + ADDR_W + BC_W + LEN_W;
  localparam int CNT_W    = $clog2(HDR_W + 1);
  localparam int N_W      = LEN_W + BC_W;
  localparam int SA_W     = ADDR_W + STEP_SH;
  localparam int MEM_BITS = 1 << MEM_AW;

  typedef enum logic [3:0] {
    S_IDLE, S_ID0, S_ID1, S_HDR, S_RD, S_WR, S_ST0, S_ST1, S_TRL
  } st_t;

  st_t              state;
  logic             hc_q, hd_q, tog;
  logic [7:0]       win;
  logic [HDR_W-2:0] hdr;
  logic [CNT_W-1:0] cnt;
  logic [MEM_AW-1:0] ptr;
  logic [N_W-1:0]   rem;
  logic             mem [MEM_BITS];
  logic             present;

  initial for (int i = 0; i < MEM_BITS; i++) mem[i] = 1'b1;

  wire rise = host_clk & ~hc_q;
  wire fall = ~host_clk & hc_q;
  wire dchg = host_data ^ hd_q;
  wire abort = (state != S_IDLE) &&
               ((dchg && host_clk && hc_q) || (dchg && !host_clk && !hc_q && tog));

  wire [7:0]       win_nx   = {win[6:0], host_data};
  wire [HDR_W-1:0] hdr_full = {host_data, hdr};
  wire             f_dir    = hdr_full[0];
  wire [ADDR_W-1:0] f_addr  = hdr_full[ADDR_W:1];
  wire [BC_W-1:0]  f_bc     = hdr_full[ADDR_W+BC_W:ADDR_W+1];
  wire [LEN_W-1:0] f_len    = hdr_full[HDR_W-1:ADDR_W+BC_W+1];
  wire [N_W-1:0]   n_bits   = (N_W'(f_len) << BC_W) + N_W'(f_bc);
  wire [SA_W-1:0]  start_sa = {f_addr, {STEP_SH{1'b0}}};
  wire             last_bit = (rem == N_W'(1));

  assign pad_lock = (state != S_IDLE);

  always_comb begin
    present = 1'b0;
    case (state)
      S_ID1:   present = 1'b1;
      S_RD:    present = mem[ptr];
      S_ST0:   present = 1'b1;
      default: present = 1'b0;
    endcase
  end

  always_ff @(posedge clk)
    if (rst_n && !abort && rise && state == S_WR) mem[ptr] <= host_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      hc_q     <= 1'b0;
      hd_q     <= 1'b0;
      tog      <= 1'b0;
      win      <= '0;
      hdr      <= '0;
      cnt      <= '0;
      ptr      <= '0;
      rem      <= '0;
      ret_data <= 1'b0;
      ret_id   <= 1'b0;
    end else begin
      hc_q <= host_clk;
      hd_q <= host_data;
      if (abort) begin
        state    <= S_IDLE;
        win      <= '0;
        tog      <= 1'b0;
        ret_data <= 1'b0;
        ret_id   <= 1'b0;
      end else begin
        if (rise) tog <= 1'b0;
        else if (dchg && !host_clk) tog <= 1'b1;

        if (rise) begin
          case (state)
            S_IDLE: begin
              win <= win_nx;
              if (win_nx == SYNC_BYTE) state <= S_ID0;
            end
            S_ID0: state <= S_ID1;
            S_ID1: begin
              state <= S_HDR;
              cnt   <= '0;
            end
            S_HDR: begin
              hdr <= hdr_full[HDR_W-1:1];
              cnt <= cnt + 1'b1;
              if (cnt == CNT_W'(HDR_W - 1)) begin
                cnt <= '0;
                ptr <= MEM_AW'(start_sa);
                rem <= n_bits;
                if (f_dir) state <= (n_bits == '0) ? S_TRL : S_RD;
                else       state <= (n_bits == '0) ? S_ST0 : S_WR;
              end
            end
            S_RD: begin
              ptr <= ptr + 1'b1;
              rem <= rem - 1'b1;
              if (last_bit) state <= S_TRL;
            end
            S_WR: begin
              ptr <= ptr + 1'b1;
              rem <= rem - 1'b1;
              if (last_bit) state <= S_ST0;
            end
            S_ST0: state <= S_ST1;
            S_ST1: begin
              state <= S_TRL;
              cnt   <= '0;
            end
            S_TRL: begin
              cnt <= cnt + 1'b1;
              if (cnt == CNT_W'(2)) begin
                state <= S_IDLE;
                win   <= '0;
              end
            end
            default: state <= S_IDLE;
          endcase
        end

        if (fall) begin
          ret_id   <= (state == S_ID0);
          ret_data <= present;
        end
      end
    end
  end
endmodule

// File: rtl/save_mem_emu_chk.sv
module save_mem_emu_chk (
  input logic clk,
  input logic rst_n,
  input logic host_clk,
  input logic host_data,
  input logic ret_data,
  input logic ret_id,
  input logic pad_lock
);
  a_r1_lock_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_lock) |-> $past(host_clk) && !$past(host_clk, 2));

  a_r8_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pad_lock) |-> ($past(host_clk) && !$past(host_clk, 2)) ||
                        ($past(host_data) != $past(host_data, 2)));

  a_r9_high_change_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    pad_lock && host_clk && $past(host_clk) && (host_data != $past(host_data))
    |=> !pad_lock);

  a_r10_double_toggle_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    pad_lock && !host_clk && !$past(host_clk) && !$past(host_clk, 2) &&
    (host_data != $past(host_data)) && ($past(host_data) != $past(host_data, 2))
    |=> !pad_lock);

  a_r12_ret_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    host_clk && $past(host_clk) && $stable(host_data) &&
    ($past(host_data) == $past(host_data, 2))
    |-> $stable(ret_data) && $stable(ret_id));

  a_r12_id_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ret_id |-> pad_lock);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_lock |-> !ret_data);
endmodule

bind save_mem_emu save_mem_emu_chk i_chk (
  .clk(clk), .rst_n(rst_n), .host_clk(host_clk), .host_data(host_data),
  .ret_data(ret_data), .ret_id(ret_id), .pad_lock(pad_lock)
);

// File: tb/test_save_mem_emu.sv
module test_save_mem_emu;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW     = 12;
  localparam int MEM_BITS   = 1 << MEM_AW;
  localparam int WD_CYCLES  = 190000;

  logic clk = 1'b0;
  logic rst_n, host_clk, host_data;
  logic ret_data, ret_id, pad_lock;
  int   vectors = 0, miscmp = 0;
  bit   ref_mem [MEM_BITS];

  always #(CLK_PERIOD/2) clk = ~clk;

  save_mem_emu #(.MEM_AW(MEM_AW)) i_save_mem_emu (
    .clk(clk), .rst_n(rst_n), .host_clk(host_clk), .host_data(host_data),
    .ret_data(ret_data), .ret_id(ret_id), .pad_lock(pad_lock)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscmp++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic int bitpos(input int addr, input int k);
    return (addr * 1024 + k) % MEM_BITS;
  endfunction

  function automatic logic [30:0] mk_hdr(input bit dir, input int addr, input int bc, input int len);
    return {17'(len), 3'(bc), 10'(addr), dir};
  endfunction

  task automatic put_bit(input bit b);
    host_data = b;
    step(2);
    host_clk = 1'b1;
    step(3);
    host_clk = 1'b0;
    step(3);
  endtask

  task automatic get_bit(output bit b, output bit id);
    b  = ret_data;
    id = ret_id;
    host_clk = 1'b1;
    step(3);
    host_clk = 1'b0;
    step(3);
  endtask

  task automatic wake();
    bit b, id;
    for (int i = 7; i >= 0; i--) put_bit(8'hA8 >> i);
    chk("R1 lock after sync", pad_lock, 1);
    get_bit(b, id);
    chk("R2 first id bit", {id, b}, 2'b10);
    get_bit(b, id);
    chk("R2 second id bit", {id, b}, 2'b01);
  endtask

  task automatic send_hdr(input bit dir, input int addr, input int bc, input int len);
    logic [30:0] h = mk_hdr(dir, addr, bc, len);
    for (int i = 0; i < 31; i++) put_bit(h[i]);
  endtask

  task automatic trailer(input string req);
    for (int i = 0; i < 3; i++) put_bit(1'b0);
    chk(req, pad_lock, 0);
  endtask

  task automatic do_read(input int addr, input int len, input int bc, input string req);
    bit b, id;
    wake();
    send_hdr(1'b1, addr, bc, len);
    for (int k = 0; k < len * 8 + bc; k++) begin
      get_bit(b, id);
      chk(req, b, ref_mem[bitpos(addr, k)]);
    end
    trailer("R8 idle after read trailer");
  endtask

  task automatic do_write(input int addr, input int len, input int bc,
                          input bit use_pat, input logic [31:0] pat);
    bit b, id, d;
    wake();
    send_hdr(1'b0, addr, bc, len);
    for (int k = 0; k < len * 8 + bc; k++) begin
      d = use_pat ? pat[k % 32] : 1'($urandom);
      put_bit(d);
      ref_mem[bitpos(addr, k)] = d;
    end
    get_bit(b, id);
    chk("R7 status first", b, 1);
    get_bit(b, id);
    chk("R7 status second", b, 0);
    trailer("R8 idle after write trailer");
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    vectors++;
    miscmp++;
    $display("FAIL watchdog expired, run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    bit b, id;
    void'($urandom(32'd20240607));
    for (int i = 0; i < MEM_BITS; i++) ref_mem[i] = 1'b1;
    rst_n = 1'b0; host_clk = 1'b0; host_data = 1'b0;
    step(5);
    chk("R12 reset outputs", {pad_lock, ret_id, ret_data}, 3'b000);
    rst_n = 1'b1;
    step(3);

    // R1: patterns that never form the sync byte
    begin
      logic [7:0] junk [3] = '{8'hA0, 8'h54, 8'hFF};
      for (int j = 0; j < 3; j++) begin
        for (int i = 7; i >= 0; i--) put_bit(junk[j][i]);
        chk("R1 no lock on non-sync byte", pad_lock, 0);
      end
    end

    do_read(2, 1, 0, "R6 unwritten reads one");

    // R6: partial byte keeps the other bits
    do_write(0, 1, 0, 1'b1, 32'h0);
    do_write(0, 0, 3, 1'b1, 32'h3);
    do_read(0, 1, 0, "R6 partial write byte");

    do_read(0, 0, 1, "R4 one-bit read");
    do_write(1, 0, 0, 1'b1, 32'h0);
    do_read(1, 0, 0, "R4 zero read");

    // R9: data change while clock high
    wake();
    for (int i = 0; i < 5; i++) put_bit(1'b1);
    host_data = 1'b0; step(1);
    host_clk = 1'b1; step(3);
    host_data = 1'b1; step(3);
    chk("R9 abort on high-phase change", {pad_lock, ret_data, ret_id}, 3'b000);
    host_clk = 1'b0; step(3);
    do_read(0, 0, 3, "R9 recovery read");

    // R10: two changes while clock low
    wake();
    for (int i = 0; i < 5; i++) put_bit(1'b0);
    host_data = 1'b1; step(2);
    host_data = 1'b0; step(3);
    chk("R10 abort on double toggle", pad_lock, 0);
    do_read(0, 0, 2, "R10 recovery read");

    // R11: stalled read, sync is taken as data clocks
    do_write(1, 2, 0, 1'b0, 32'h0);
    wake();
    send_hdr(1'b1, 1, 0, 2);
    for (int k = 0; k < 4; k++) begin
      get_bit(b, id);
      chk("R11 stream before stall", b, ref_mem[bitpos(1, k)]);
    end
    for (int i = 7; i >= 0; i--) put_bit(8'hA8 >> i);
    chk("R11 still locked after wakeup", {pad_lock, ret_id}, 2'b10);
    for (int k = 12; k < 16; k++) begin
      get_bit(b, id);
      chk("R11 stream resumes", b, ref_mem[bitpos(1, k)]);
    end
    trailer("R11 released after exhausting count");

    // R5: long run across 128-byte steps and array wrap
    do_write(3, 130, 0, 1'b0, 32'h0);
    do_read(3, 130, 0, "R5 sequential wrap read");
    do_read(2, 3, 5, "R5 offset read");

    // R3: random headers
    for (int t = 0; t < 30; t++) begin
      int a  = int'($urandom % 1024);
      int ln = int'($urandom % 5);
      int bc = int'($urandom % 8);
      if ($urandom % 2) do_write(a, ln, bc, 1'b0, 32'h0);
      else              do_read(a, ln, bc, "R3 random header read");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule